// File: doc/BRIEF.md
# Two-Cycle Search Command Front End

This block accepts a search command that the host spreads over two back-to-back clock cycles. In the first cycle (A) the command bits name a global mask register pair and the upper bits of the address to report. In the second cycle (B) the same command bits name a comparand register pair and one of eight result registers. The 72-bit data word seen on the bus in each cycle is kept: the two words together form a 144-bit comparand that is stored in the named pair. The key from cycle A is then compared under masks against a small local entry array. The lowest matching entry index, with the reported upper address bits and a hit flag, is written into the named result register.

The block checks the command protocol. A cycle A with command bit 2 set, or a cycle A that is not followed at once by cycle B, raises a one-cycle protocol error and updates nothing. A difference between the data words of the two cycles is reported next to the result. The entries, the per-entry masks and the global mask registers are loaded through a simple write port. The result registers and comparand pairs can be read back through select inputs.

Top module: `srch_front`

## Requirements
- R1: After reset, res_valid, proto_err and data_mismatch are 0, every result register and comparand pair reads 0, and no entry is valid.
- R2: A cycle with cmdv=1 and cmd[1:0]=2'b10 starts a search as cycle A if the block is idle. In cycle A, {cmd[10],cmd[5:3]} is the global mask pair index g, and the compare uses global mask register 2*g. cmd[8:6] gives the reported address bits [23:21].
- R3: In cycle B (the next cycle, again cmdv=1 and cmd[1:0]=2'b10), cmd[5:2] names the comparand pair. It is written with {A data, B data}, the cycle A data in bits [143:72], and cmp_data shows the pair chosen by cmp_sel.
- R4: An entry matches when it is valid and, at every bit where both the global mask bit and the entry mask bit are 0, the entry data equals the cycle A data. Set mask bits are don't care.
- R5: When several entries match, the lowest index wins. The result register becomes {1'b1, hi[2:0], 17'b0, index[3:0]}: hit flag in bit 24, hi in bits [23:21], index in [3:0].
- R6: When no entry matches, the result register becomes {1'b0, hi[2:0], 21'b0}, so its hit flag is cleared.
- R7: In cycle B, cmd[8:6] selects which of the eight result registers is written. The other seven keep their values. ssr_data shows the register chosen by ssr_sel.
- R8: res_valid is high for exactly one cycle, in the second cycle after cycle B, and the new result register value is readable from that cycle on.
- R9: If cmd[2]=1 in cycle A, or if the cycle after cycle A is not a search cycle, then proto_err pulses for one cycle, in the cycle after the offending one. No result register or comparand pair is written, and the block returns to idle.
- R10: data_mismatch pulses together with res_valid when the cycle A and cycle B data words differ. The search still completes using the cycle A data.
- R11: When wr_en=1, wr_tgt selects the target. 2'b00 writes entry data at wr_addr[3:0] and marks the entry valid. 2'b01 writes the entry mask at wr_addr[3:0]. 2'b10 writes global mask register wr_addr[4:0]. 2'b11 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmdv | input | 1 | Command valid |
| cmd | input | 11 | Command bits; meaning depends on cycle A or B |
| dq | input | 72 | Search data word |
| wr_en | input | 1 | Table write enable |
| wr_tgt | input | 2 | Write target: entry data, entry mask, global mask, none |
| wr_addr | input | 5 | Write address |
| wr_data | input | 72 | Write data |
| ssr_sel | input | 3 | Result register read select |
| ssr_data | output | 25 | Selected result register {hit, address} |
| cmp_sel | input | 4 | Comparand pair read select |
| cmp_data | output | 144 | Selected comparand pair |
| res_valid | output | 1 | One-cycle strobe when a result register is written |
| proto_err | output | 1 | One-cycle protocol error strobe |
| data_mismatch | output | 1 | Cycle A and B data differed, with res_valid |

## Verification
The assertions assume that table writes do not land in the cycle in which a search is being compared. They also assume the host drives cycle B only right after cycle A, so a search result never overlaps the next search's issue. The bench drives every search as a closed A, B, idle sequence and loads the tables only while no search is in flight. This keeps the compare inputs stable from issue to result, and keeps any error pulse clear of a result strobe.

// File: rtl/srch_pkg.sv
// Shared constants and types of the two-cycle search front end.
// Assumes a fixed command bus layout of 11 bits.
package srch_pkg;
    localparam int CMD_W  = 11;
    localparam int HI_W   = 3;
    localparam int GIDX_W = 4;
    localparam int CIDX_W = 4;
    localparam int SSEL_W = 3;

    localparam logic [1:0] OP_SEARCH = 2'b10;

    typedef enum logic [1:0] {
        TGT_DATA  = 2'b00,
        TGT_MASK  = 2'b01,
        TGT_GMASK = 2'b10,
        TGT_NONE  = 2'b11
    } wr_tgt_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_GOT_A = 1'b1
    } cmd_state_e;

    typedef struct packed {
        logic [GIDX_W-1:0] gm_idx;
        logic [HI_W-1:0]   hi;
        logic [SSEL_W-1:0] ssr_idx;
    } srch_ctl_t;
endpackage

// File: rtl/srch_reg_bank.sv
// Generic bank of reset-to-zero registers with one write and one
// combinational read port. Assumes DEPTH is a power of two.
module srch_reg_bank #(
    parameter int WIDTH = 72,
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] regs_q [DEPTH];

    // Register storage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                regs_q[i] <= '0;
            end
        end else if (we) begin
            regs_q[waddr] <= wdata;
        end
    end

    // Combinational read.
    always_comb begin
        rdata = regs_q[raddr];
    end
endmodule

// File: rtl/srch_cmd_fsm.sv
// Captures the two-cycle search command. In cycle A it latches the
// mask pair index, the reported high address bits and the key. In
// cycle B it writes the comparand pair and issues the search. It
// flags protocol errors. Assumes inputs are synchronous to clk.
module srch_cmd_fsm
    import srch_pkg::*;
#(
    parameter int DQ_W = 72
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmdv,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [DQ_W-1:0]   dq,
    output logic              iss_valid,
    output srch_ctl_t         iss_ctl,
    output logic [DQ_W-1:0]   iss_key,
    output logic              iss_mismatch,
    output logic              cmp_we,
    output logic [CIDX_W-1:0] cmp_widx,
    output logic [2*DQ_W-1:0] cmp_wdata,
    output logic              proto_err
);
    cmd_state_e        st_q;
    logic [GIDX_W-1:0] a_gm_q;
    logic [HI_W-1:0]   a_hi_q;
    logic [DQ_W-1:0]   a_data_q;
    logic              is_srch;
    logic              unused_cmd9;

    assign unused_cmd9 = cmd[9];

    // Decode a search code on the bus.
    always_comb begin
        is_srch = cmdv && (cmd[1:0] == OP_SEARCH);
    end

    // Cycle A/B sequencing, issue and error strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= ST_IDLE;
            a_gm_q       <= '0;
            a_hi_q       <= '0;
            a_data_q     <= '0;
            iss_valid    <= 1'b0;
            iss_ctl      <= '0;
            iss_key      <= '0;
            iss_mismatch <= 1'b0;
            proto_err    <= 1'b0;
        end else begin
            iss_valid <= 1'b0;
            proto_err <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (is_srch) begin
                        if (cmd[2]) begin
                            proto_err <= 1'b1;
                        end else begin
                            st_q     <= ST_GOT_A;
                            a_gm_q   <= {cmd[10], cmd[5:3]};
                            a_hi_q   <= cmd[8:6];
                            a_data_q <= dq;
                        end
                    end
                end
                default: begin
                    st_q <= ST_IDLE;
                    if (is_srch) begin
                        iss_valid    <= 1'b1;
                        iss_ctl      <= '{gm_idx: a_gm_q, hi: a_hi_q, ssr_idx: cmd[8:6]};
                        iss_key      <= a_data_q;
                        iss_mismatch <= (a_data_q != dq);
                    end else begin
                        proto_err <= 1'b1;
                    end
                end
            endcase
        end
    end

    // Comparand pair write during cycle B.
    always_comb begin
        cmp_we    = (st_q == ST_GOT_A) && is_srch;
        cmp_widx  = cmd[5:2];
        cmp_wdata = {a_data_q, dq};
    end
endmodule

// File: rtl/srch_match_array.sv
// Local entry array with per-entry data, mask and valid flag, a
// masked compare of every entry against the key and a lowest-index
// priority encoder. Assumes ENTRIES is a power of two.
module srch_match_array #(
    parameter int DQ_W    = 72,
    parameter int ENTRIES = 16,
    parameter int IW      = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_data,
    input  logic               we_mask,
    input  logic [IW-1:0]      waddr,
    input  logic [DQ_W-1:0]    wdata,
    input  logic [DQ_W-1:0]    key,
    input  logic [DQ_W-1:0]    gmask,
    output logic [ENTRIES-1:0] match_vec,
    output logic               hit,
    output logic [IW-1:0]      win_idx
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic [DQ_W-1:0] d_q;
        logic [DQ_W-1:0] m_q;
        logic            v_q;

        // Per-entry storage; a data write also validates the entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                d_q <= '0;
                m_q <= '0;
                v_q <= 1'b0;
            end else begin
                if (we_data && (waddr == IW'(g))) begin
                    d_q <= wdata;
                    v_q <= 1'b1;
                end
                if (we_mask && (waddr == IW'(g))) begin
                    m_q <= wdata;
                end
            end
        end

        // Masked compare of this entry.
        assign match_vec[g] = v_q && (((key ^ d_q) & ~gmask & ~m_q) == '0);
    end

    // Lowest-index winner.
    always_comb begin
        win_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                win_idx = IW'(i);
            end
        end
        hit = |match_vec;
    end
endmodule

// File: rtl/srch_result_file.sv
// Eight search result registers, each {hit, address}, written one
// cycle after issue, with a result strobe and mismatch strobe.
// Assumes ADDR_W leaves room for the high bits and the index.
module srch_result_file
    import srch_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int IW     = 4,
    parameter int NSSR   = 8,
    parameter int SW     = $clog2(NSSR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SW-1:0]     wr_sel,
    input  logic              hit,
    input  logic [HI_W-1:0]   hi,
    input  logic [IW-1:0]     idx,
    input  logic              mismatch_in,
    input  logic [SW-1:0]     rd_sel,
    output logic [ADDR_W:0]   rd_data,
    output logic              res_valid,
    output logic              data_mismatch
);
    localparam int PAD_W = ADDR_W - HI_W - IW;

    logic [ADDR_W:0] ssr_q [NSSR];
    logic [IW-1:0]   idx_eff;

    // Index reads as zero on a miss.
    always_comb begin
        idx_eff = hit ? idx : '0;
    end

    // Result registers and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSSR; i++) begin
                ssr_q[i] <= '0;
            end
            res_valid     <= 1'b0;
            data_mismatch <= 1'b0;
        end else begin
            if (wr_en) begin
                ssr_q[wr_sel] <= {hit, hi, {PAD_W{1'b0}}, idx_eff};
            end
            res_valid     <= wr_en;
            data_mismatch <= wr_en && mismatch_in;
        end
    end

    // Combinational readout.
    always_comb begin
        rd_data = ssr_q[rd_sel];
    end
endmodule

// File: rtl/srch_front.sv
// Top of the two-cycle search front end: command capture, global
// mask and comparand banks, entry array and result registers.
// Assumes ENTRIES is at most 32 and table writes are not made
// while a search is in its compare cycle.
module srch_front
    import srch_pkg::*;
#(
    parameter int DQ_W    = 72,
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmdv,
    input  logic [10:0]          cmd,
    input  logic [DQ_W-1:0]      dq,
    input  logic                 wr_en,
    input  logic [1:0]           wr_tgt,
    input  logic [4:0]           wr_addr,
    input  logic [DQ_W-1:0]      wr_data,
    input  logic [2:0]           ssr_sel,
    output logic [ADDR_W:0]      ssr_data,
    input  logic [3:0]           cmp_sel,
    output logic [2*DQ_W-1:0]    cmp_data,
    output logic                 res_valid,
    output logic                 proto_err,
    output logic                 data_mismatch
);
    localparam int IW        = $clog2(ENTRIES);
    localparam int GM_DEPTH  = 2 ** (GIDX_W + 1);
    localparam int CMP_DEPTH = 2 ** CIDX_W;

    logic              iss_valid;
    srch_ctl_t         iss_ctl;
    logic [DQ_W-1:0]   iss_key;
    logic              iss_mismatch;
    logic              cmp_we;
    logic [CIDX_W-1:0] cmp_widx;
    logic [2*DQ_W-1:0] cmp_wdata;
    logic [DQ_W-1:0]   gmask;
    logic [ENTRIES-1:0] match_vec;
    logic              hit;
    logic [IW-1:0]     win_idx;
    logic              we_data;
    logic              we_mask;
    logic              we_gm;
    wr_tgt_e           tgt;

    // Decode the table write target.
    always_comb begin
        tgt     = wr_tgt_e'(wr_tgt);
        we_data = wr_en && (tgt == TGT_DATA);
        we_mask = wr_en && (tgt == TGT_MASK);
        we_gm   = wr_en && (tgt == TGT_GMASK);
    end

    srch_cmd_fsm #(.DQ_W(DQ_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .cmdv(cmdv), .cmd(cmd), .dq(dq),
        .iss_valid(iss_valid), .iss_ctl(iss_ctl), .iss_key(iss_key),
        .iss_mismatch(iss_mismatch), .cmp_we(cmp_we), .cmp_widx(cmp_widx),
        .cmp_wdata(cmp_wdata), .proto_err(proto_err)
    );

    srch_reg_bank #(.WIDTH(DQ_W), .DEPTH(GM_DEPTH)) i_gmask (
        .clk(clk), .rst_n(rst_n), .we(we_gm), .waddr(wr_addr),
        .wdata(wr_data), .raddr({iss_ctl.gm_idx, 1'b0}), .rdata(gmask)
    );

    srch_reg_bank #(.WIDTH(2*DQ_W), .DEPTH(CMP_DEPTH)) i_cmp (
        .clk(clk), .rst_n(rst_n), .we(cmp_we), .waddr(cmp_widx),
        .wdata(cmp_wdata), .raddr(cmp_sel), .rdata(cmp_data)
    );

    srch_match_array #(.DQ_W(DQ_W), .ENTRIES(ENTRIES)) i_match (
        .clk(clk), .rst_n(rst_n), .we_data(we_data), .we_mask(we_mask),
        .waddr(wr_addr[IW-1:0]), .wdata(wr_data), .key(iss_key),
        .gmask(gmask), .match_vec(match_vec), .hit(hit), .win_idx(win_idx)
    );

    srch_result_file #(.ADDR_W(ADDR_W), .IW(IW), .NSSR(8)) i_res (
        .clk(clk), .rst_n(rst_n), .wr_en(iss_valid), .wr_sel(iss_ctl.ssr_idx),
        .hit(hit), .hi(iss_ctl.hi), .idx(win_idx), .mismatch_in(iss_mismatch),
        .rd_sel(ssr_sel), .rd_data(ssr_data), .res_valid(res_valid),
        .data_mismatch(data_mismatch)
    );
endmodule

// File: rtl/srch_front_chk.sv
// Protocol and result checker for srch_front, attached by bind.
// Assumes the host never overlaps a new cycle B with a result.
module srch_front_chk #(
    parameter int ENTRIES = 16,
    parameter int IW      = $clog2(ENTRIES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               iss_valid,
    input logic               res_valid,
    input logic               proto_err,
    input logic               data_mismatch,
    input logic [ENTRIES-1:0] match_vec,
    input logic               hit,
    input logic [IW-1:0]      win_idx
);
    logic [ENTRIES-1:0] below_win;

    always_comb begin
        below_win = (ENTRIES'(1) << win_idx) - ENTRIES'(1);
    end

    AST_RES_FOLLOWS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n) iss_valid |=> res_valid); // R8
    AST_RES_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> $past(iss_valid)); // R8
    AST_RES_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) res_valid |=> !res_valid); // R8
    AST_ERR_BLOCKS_RESULT: assert property (@(posedge clk) disable iff (!rst_n) proto_err |=> !res_valid); // R9
    AST_ERR_NOT_ISSUE: assert property (@(posedge clk) disable iff (!rst_n) !(proto_err && iss_valid)); // R9
    AST_WIN_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n) hit |-> (match_vec[win_idx] && ((match_vec & below_win) == '0))); // R5
    AST_MISMATCH_WITH_RES: assert property (@(posedge clk) disable iff (!rst_n) data_mismatch |-> res_valid); // R10
endmodule

bind srch_front srch_front_chk #(.ENTRIES(ENTRIES)) i_chk (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .res_valid(res_valid),
    .proto_err(proto_err), .data_mismatch(data_mismatch),
    .match_vec(match_vec), .hit(hit), .win_idx(win_idx)
);

// File: tb/test_srch_front.sv
`timescale 1ns/1ps
module test_srch_front;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmdv = 1'b0;
    logic [10:0]  cmd = '0;
    logic [71:0]  dq = '0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_tgt = '0;
    logic [4:0]   wr_addr = '0;
    logic [71:0]  wr_data = '0;
    logic [2:0]   ssr_sel = '0;
    logic [24:0]  ssr_data;
    logic [3:0]   cmp_sel = '0;
    logic [143:0] cmp_data;
    logic         res_valid;
    logic         proto_err;
    logic         data_mismatch;

    int checks = 0;
    int errors = 0;

    logic [71:0]  m_ed [16];
    logic [71:0]  m_em [16];
    logic         m_ev [16];
    logic [71:0]  m_gm [32];
    logic [24:0]  m_ssr [8];
    logic [143:0] m_cmp [16];

    srch_front i_srch_front (
        .clk(clk), .rst_n(rst_n), .cmdv(cmdv), .cmd(cmd), .dq(dq),
        .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_addr(wr_addr), .wr_data(wr_data),
        .ssr_sel(ssr_sel), .ssr_data(ssr_data), .cmp_sel(cmp_sel),
        .cmp_data(cmp_data), .res_valid(res_valid), .proto_err(proto_err),
        .data_mismatch(data_mismatch)
    );

    always #4 clk = ~clk;

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [24:0] model_ssr(input logic [71:0] key, input logic [3:0] gm, input logic [2:0] hi);
        logic [71:0] g;
        g = m_gm[{gm, 1'b0}];
        for (int i = 0; i < 16; i++) begin
            if (m_ev[i] && (((key ^ m_ed[i]) & ~g & ~m_em[i]) == '0)) begin
                return {1'b1, hi, 17'b0, 4'(i)};
            end
        end
        return {1'b0, hi, 21'b0};
    endfunction

    task automatic wr(input logic [1:0] tgt, input logic [4:0] addr, input logic [71:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_tgt = tgt; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        case (tgt)
            2'b00: begin m_ed[addr[3:0]] = data; m_ev[addr[3:0]] = 1'b1; end
            2'b01: m_em[addr[3:0]] = data;
            2'b10: m_gm[addr] = data;
            default: ;
        endcase
    endtask

    task automatic check_all_ssr(input string req);
        for (int s = 0; s < 8; s++) begin
            ssr_sel = 3'(s);
            #1;
            chk(req, 160'(ssr_data), 160'(m_ssr[s]));
        end
    endtask

    task automatic do_search(input string req, input logic [3:0] gm, input logic [2:0] hi,
                             input logic [3:0] cidx, input logic [2:0] sel,
                             input logic [71:0] da, input logic [71:0] db);
        logic [24:0] exp;
        exp = model_ssr(da, gm, hi);
        @(negedge clk);
        cmdv = 1'b1; cmd = {gm[3], 1'b0, hi, gm[2:0], 1'b0, 2'b10}; dq = da;
        @(negedge clk);
        cmd = {2'b00, sel, cidx, 2'b10}; dq = db;
        @(negedge clk);
        cmdv = 1'b0; cmd = '0; dq = '0; ssr_sel = sel; cmp_sel = cidx;
        #1;
        chk("R8 early", 160'(res_valid), 160'(0));
        @(negedge clk);
        chk("R8 strobe", 160'(res_valid), 160'(1));
        chk("R10", 160'(data_mismatch), 160'(da != db));
        chk(req, 160'(ssr_data), 160'(exp));
        chk("R3", 160'(cmp_data), 160'({da, db}));
        m_ssr[sel] = exp;
        m_cmp[cidx] = {da, db};
        @(negedge clk);
        chk("R8 single", 160'(res_valid), 160'(0));
    endtask

    task automatic t_reset();
        chk("R1 res_valid", 160'(res_valid), 160'(0));
        chk("R1 proto_err", 160'(proto_err), 160'(0));
        chk("R1 mismatch", 160'(data_mismatch), 160'(0));
        cmp_sel = 4'd5;
        #1;
        chk("R1 cmp", 160'(cmp_data), 160'(0));
        check_all_ssr("R1 ssr");
    endtask

    task automatic t_load();
        wr(2'b00, 5'd0, 72'h11);
        wr(2'b00, 5'd1, 72'hAB_CDEF);
        wr(2'b00, 5'd2, 72'hAB_CDEF);
        wr(2'b00, 5'd3, 72'hFF00);
        wr(2'b01, 5'd3, 72'h00FF);
        wr(2'b00, 5'd5, 72'h5000);
        wr(2'b00, 5'd6, 72'h80_0000_0000_0000_0001);
        wr(2'b10, 5'd6, 72'h0F);
        wr(2'b10, 5'd7, 72'h0F);
        wr(2'b10, 5'd18, 72'hFF_0000_0000_0000_0000);
        wr(2'b10, 5'd19, 72'hFF_0000_0000_0000_0000);
    endtask

    task automatic t_proto_cmd2();
        @(negedge clk);
        cmdv = 1'b1; cmd = {1'b0, 1'b0, 3'd1, 3'd0, 1'b1, 2'b10}; dq = 72'h11;
        @(negedge clk);
        cmdv = 1'b0; cmd = '0; dq = '0;
        chk("R9 cmd2 err", 160'(proto_err), 160'(1));
        @(negedge clk);
        chk("R9 cmd2 pulse", 160'(proto_err), 160'(0));
        chk("R9 cmd2 nores", 160'(res_valid), 160'(0));
        @(negedge clk);
        chk("R9 cmd2 nores2", 160'(res_valid), 160'(0));
        check_all_ssr("R9 cmd2 ssr");
    endtask

    task automatic t_proto_noB();
        @(negedge clk);
        cmdv = 1'b1; cmd = {1'b0, 1'b0, 3'd2, 3'd0, 1'b0, 2'b10}; dq = 72'h11;
        @(negedge clk);
        cmdv = 1'b0; cmd = {2'b00, 3'd0, 4'd9, 2'b10};
        @(negedge clk);
        cmd = '0; dq = '0;
        chk("R9 noB err", 160'(proto_err), 160'(1));
        @(negedge clk);
        chk("R9 noB nores", 160'(res_valid), 160'(0));
        chk("R9 noB pulse", 160'(proto_err), 160'(0));
        cmp_sel = 4'd9;
        #1;
        chk("R9 noB cmp", 160'(cmp_data), 160'(m_cmp[9]));
        check_all_ssr("R9 noB ssr");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_ed[i] = '0; m_em[i] = '0; m_ev[i] = 1'b0; m_cmp[i] = '0;
        end
        for (int i = 0; i < 32; i++) m_gm[i] = '0;
        for (int i = 0; i < 8; i++) m_ssr[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        // R4: unloaded entries never match
        do_search("R4 invalid", 4'd0, 3'd1, 4'd0, 3'd0, 72'h0, 72'h0);
        t_load();
        do_search("R5 exact", 4'd0, 3'd5, 4'd1, 3'd2, 72'h11, 72'h11);
        do_search("R5 lowest", 4'd0, 3'd3, 4'd2, 3'd3, 72'hAB_CDEF, 72'hAB_CDEF);
        do_search("R4 entry mask", 4'd0, 3'd7, 4'd3, 3'd4, 72'hFF37, 72'hFF37);
        do_search("R6 miss", 4'd0, 3'd6, 4'd4, 3'd2, 72'hFE37, 72'hFE37);
        do_search("R2 gmask pair3", 4'd3, 3'd1, 4'd5, 3'd5, 72'h5003, 72'h5003);
        do_search("R6 no gmask", 4'd0, 3'd1, 4'd6, 3'd6, 72'h5003, 72'h5003);
        do_search("R2 gmask pair9", 4'd9, 3'd4, 4'd15, 3'd7, 72'h3C_0000_0000_0000_0001, 72'h3C_0000_0000_0000_0001);
        do_search("R10 mismatch", 4'd0, 3'd2, 4'd7, 3'd1, 72'h11, 72'h22);
        check_all_ssr("R7 steering");
        wr(2'b11, 5'd0, 72'h99);
        do_search("R11 tgt none", 4'd0, 3'd0, 4'd8, 3'd0, 72'h11, 72'h11);
        wr(2'b01, 5'd0, 72'hFF);
        do_search("R11 mask write", 4'd0, 3'd0, 4'd8, 3'd0, 72'h42, 72'h42);
        t_proto_cmd2();
        t_proto_noB();
        do_search("R9 recovery", 4'd0, 3'd1, 4'd10, 3'd1, 72'hAB_CDEF, 72'hAB_CDEF);
        check_all_ssr("R7 final");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule